// File: doc/BRIEF.md
# Multi-Channel Memory-Mapped PWM Generator

This block produces a set of independent pulse-width-modulated outputs, one bit per channel, with up to sixteen channels. Each channel is described by three 32-bit counts of core clock cycles: a period, a high-time (duty) and a phase offset that shifts where the high window starts inside the period. Software programs these values through a simple single-cycle 32-bit register port with a write side (word address, data, byte strobes) and a separate read side (word address in, data out one cycle later).

Channel settings are staged. A write only changes a shadow copy; the outputs keep running on the active copy until software sets the load bit in the control word. At that moment every channel's shadow settings move to the active copy in the same clock edge, and every channel counter restarts at zero together, so all outputs stay phase-aligned. A sticky halt bit in the same control word freezes all counters at zero and drives all outputs low, without losing any programmed value. Fixed read-only words give an identification constant, a version code and the number of channels built.

Top module: `pwm_bank`

## Requirements
- R1: Reading word 3 (byte offset 0x0C) returns 0x601A3471; bus_rdata always shows the word addressed by bus_raddr at the previous clock edge.
- R2: Word 0 (0x00) reads 0x00020000 (major in [31:16] = 2, minor in [15:8] = 0, patch in [7:0] = 0) and word 5 (0x14) reads the channel count NUM_CH.
- R3: Channel n has its period at byte 0x40+4n, duty at 0x80+4n and offset at 0xC0+4n; writes merge only the bytes whose strobe bit is set (bit i covers data bits 8i+7..8i), and reads return the staged value.
- R4: Writes to period, duty or offset leave the outputs unchanged until a load; the load command is bit 1 of the control word at 0x10, it clears itself and always reads back as 0.
- R5: A load copies the staged settings of every channel to the active settings in the same edge and restarts all counters at 0; the k-th cycle after the load edge (k = 1, 2, ...) shows the output for count (k-1) mod period.
- R6: With period P > 0 and 0 < duty D < P, the output for count c is high exactly when (c - O) mod P < D, where O is the offset; an offset of P or more acts as offset 0.
- R7: A duty of 0 keeps the output low and a duty greater than or equal to a non-zero period keeps it high.
- R8: A period of 0 turns the channel off: its output stays low whatever the duty and offset.
- R9: Bit 0 of the control word is a sticky halt: it reads back as written, holds all counters at 0 and all outputs low from the second edge after it is set, keeps every staged and active value, and clearing it restarts all channels from count 0 with their active settings, with the same timing as a load.
- R10: Reads of unused words and of channel slots at or above NUM_CH return 0, and writes to them change nothing.
- R11: After rst_n is asserted all outputs are low and all staged values and the control word read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; all counts are in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write enable for one cycle |
| bus_waddr | input | 6 | Write word address (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte enables for the write |
| bus_raddr | input | 6 | Read word address (byte offset divided by 4) |
| bus_rdata | output | 32 | Read data, one cycle after bus_raddr |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The bench builds the block with NUM_CH set to 3, so the count word reads a value other than the maximum and slots 3 through 15 of each of the three channel regions are real out-of-range addresses whose reads and ignored writes can be observed. The three channels are each driven from a rotating table of period, duty and offset sets, so every load switches all three at once to differing shapes, including wrapped windows, zero and oversize duties, oversize offsets and a zero period. Periods are kept short so that two full periods of every shape fit into a short sampling window while the counters remain full 32-bit.

// File: rtl/pwmb_pkg.sv
package pwmb_pkg;

    localparam int unsigned CNT_W = 32;

    localparam logic [31:0] ID_WORD  = 32'h601A3471;
    localparam logic [31:0] VER_WORD = {16'd2, 8'd0, 8'd0};

    localparam logic [5:0] W_VER = 6'd0;
    localparam logic [5:0] W_ID  = 6'd3;
    localparam logic [5:0] W_CTL = 6'd4;
    localparam logic [5:0] W_NCH = 6'd5;

    localparam logic [1:0] REG_PER = 2'b01;
    localparam logic [1:0] REG_DTY = 2'b10;
    localparam logic [1:0] REG_OFS = 2'b11;

    typedef struct packed {
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] dty;
        logic [CNT_W-1:0] ofs;
    } chan_cfg_t;

    function automatic logic [31:0] merge_bytes(input logic [31:0] old_v,
                                                input logic [31:0] new_v,
                                                input logic [3:0]  strb);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) begin
            r[8*b +: 8] = strb[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/pwmb_regs.sv
module pwmb_regs
    import pwmb_pkg::*;
#(
    parameter int unsigned NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [5:0]        bus_waddr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_wstrb,
    input  logic [5:0]        bus_raddr,
    output logic [31:0]       bus_rdata,
    output chan_cfg_t [NUM_CH-1:0] act_cfg,
    output logic              load_go,
    output logic              halt
);

    typedef struct packed {
        chan_cfg_t [NUM_CH-1:0] shd;
        chan_cfg_t [NUM_CH-1:0] act;
        logic                   halt;
        logic [31:0]            rdata;
    } regs_t;

    regs_t st_d, st_q;

    logic       ctl_wr;
    logic [1:0] w_region;
    logic [3:0] w_slot;
    logic [1:0] r_region;
    logic [3:0] r_slot;

    assign w_region = bus_waddr[5:4];
    assign w_slot   = bus_waddr[3:0];
    assign r_region = bus_raddr[5:4];
    assign r_slot   = bus_raddr[3:0];
    assign ctl_wr   = bus_wr && (bus_waddr == W_CTL) && bus_wstrb[0];
    assign load_go  = ctl_wr && bus_wdata[1];

    always_comb begin
        st_d = st_q;

        if (ctl_wr) begin
            st_d.halt = bus_wdata[0];
        end

        if (bus_wr && (w_region != 2'b00)) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (w_slot == 4'(i)) begin
                    unique case (w_region)
                        REG_PER: st_d.shd[i].per = merge_bytes(st_q.shd[i].per, bus_wdata, bus_wstrb);
                        REG_DTY: st_d.shd[i].dty = merge_bytes(st_q.shd[i].dty, bus_wdata, bus_wstrb);
                        default: st_d.shd[i].ofs = merge_bytes(st_q.shd[i].ofs, bus_wdata, bus_wstrb);
                    endcase
                end
            end
        end

        if (load_go) begin
            st_d.act = st_q.shd;
        end

        st_d.rdata = '0;
        if (r_region == 2'b00) begin
            unique case (bus_raddr)
                W_VER:   st_d.rdata = VER_WORD;
                W_ID:    st_d.rdata = ID_WORD;
                W_CTL:   st_d.rdata = {31'd0, st_q.halt};
                W_NCH:   st_d.rdata = 32'(NUM_CH);
                default: st_d.rdata = '0;
            endcase
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (r_slot == 4'(i)) begin
                    unique case (r_region)
                        REG_PER: st_d.rdata = st_q.shd[i].per;
                        REG_DTY: st_d.rdata = st_q.shd[i].dty;
                        default: st_d.rdata = st_q.shd[i].ofs;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign act_cfg   = st_q.act;
    assign halt      = st_q.halt;

    // R1: identification word readable with one cycle of latency
    assert_id_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_raddr == W_ID) |=> (bus_rdata == ID_WORD));

    // R10: slots at or above the channel count read as zero
    assert_oob_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_region != 2'b00) && (32'(r_slot) >= NUM_CH)) |=> (bus_rdata == 32'd0));

    // R5: a load copies staged settings of channel 0 into its active copy
    assert_load_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_go |=> (act_cfg[0] == $past(st_q.shd[0])));

    // R4: active settings only move on a load
    assert_act_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_go |=> $stable(act_cfg));

    // R9: halt bit only changes through a control write
    assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(halt));

endmodule

// File: rtl/pwmb_chan.sv
module pwmb_chan
    import pwmb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  chan_cfg_t cfg,
    input  logic      restart,
    input  logic      halt,
    output logic      pwm
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             out;
    } chan_t;

    chan_t st_d, st_q;

    logic [CNT_W:0]   cnt_inc;
    logic [CNT_W-1:0] ofs_eff;
    logic [CNT_W:0]   pos;
    logic             in_win;

    always_comb begin
        cnt_inc = {1'b0, st_q.cnt} + 1'b1;
        ofs_eff = (cfg.ofs >= cfg.per) ? '0 : cfg.ofs;
        if (st_q.cnt >= ofs_eff) begin
            pos = {1'b0, st_q.cnt - ofs_eff};
        end else begin
            pos = {1'b0, st_q.cnt} + {1'b0, cfg.per - ofs_eff};
        end

        if ((cfg.per == '0) || (cfg.dty == '0)) begin
            in_win = 1'b0;
        end else if (cfg.dty >= cfg.per) begin
            in_win = 1'b1;
        end else begin
            in_win = (pos < {1'b0, cfg.dty});
        end

        st_d = st_q;
        if (restart || halt || (cfg.per == '0) || (cnt_inc >= {1'b0, cfg.per})) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = cnt_inc[CNT_W-1:0];
        end
        st_d.out = halt ? 1'b0 : in_win;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm = st_q.out;

    // R8: a zero period gives a low output
    assert_off_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.per == '0) |=> !pwm);

    // R6: counter stays inside the period
    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.per != '0) |-> (st_q.cnt < cfg.per));

    // R7: duty at or above the period keeps the output high
    assert_full_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && (cfg.per != '0) && (cfg.dty >= cfg.per)) |=> pwm);

    // R9: halt forces the output low
    assert_halt_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !pwm);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwmb_pkg::*;
#(
    parameter int unsigned NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [5:0]        bus_waddr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_wstrb,
    input  logic [5:0]        bus_raddr,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    chan_cfg_t [NUM_CH-1:0] act_cfg;
    logic                   load_go;
    logic                   halt;

    pwmb_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_waddr (bus_waddr),
        .bus_wdata (bus_wdata),
        .bus_wstrb (bus_wstrb),
        .bus_raddr (bus_raddr),
        .bus_rdata (bus_rdata),
        .act_cfg   (act_cfg),
        .load_go   (load_go),
        .halt      (halt)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        pwmb_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg     (act_cfg[g]),
            .restart (load_go),
            .halt    (halt),
            .pwm     (pwm_out[g])
        );
    end

    // R11: outputs are low in the first cycle after reset
    assert_rst_low_R11: assert property (@(posedge clk)
        $rose(rst_n) |-> (pwm_out == '0));

endmodule

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;

    localparam int NCH = 3;
    localparam int NV  = 10;

    // period, duty, offset
    localparam logic [95:0] VEC [NV] = '{
        {32'd10, 32'd3, 32'd0},
        {32'd10, 32'd3, 32'd8},
        {32'd7,  32'd0, 32'd2},
        {32'd5,  32'd5, 32'd1},
        {32'd6,  32'd9, 32'd0},
        {32'd0,  32'd0, 32'd0},
        {32'd0,  32'd4, 32'd1},
        {32'd8,  32'd2, 32'd12},
        {32'd1,  32'd1, 32'd0},
        {32'd4,  32'd2, 32'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_waddr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_wstrb = '0;
    logic [5:0]  bus_raddr = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] pwm_out;

    int n_chk = 0;
    int n_fail = 0;
    int k = 0;
    logic [31:0] a_per [NCH];
    logic [31:0] a_dty [NCH];
    logic [31:0] a_ofs [NCH];
    logic [31:0] s_per [NCH];
    logic [31:0] s_dty [NCH];
    logic [31:0] s_ofs [NCH];

    always #2.5 clk = ~clk;

    pwm_bank #(.NUM_CH(NCH)) u_pwm_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_raddr(bus_raddr),
        .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic model(input int unsigned kk, input logic [31:0] p,
                                   input logic [31:0] d, input logic [31:0] o);
        longint unsigned c, oo, pos;
        if (p == 0 || d == 0) return 1'b0;
        if (d >= p) return 1'b1;
        c   = longint'(kk - 1) % p;
        oo  = (o >= p) ? 0 : o;
        pos = (c + p - oo) % p;
        return pos < d;
    endfunction

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        k++;
        bus_wr = 1'b1; bus_waddr = a; bus_wdata = d; bus_wstrb = s;
        @(negedge clk);
        k++;
        bus_wr = 1'b0; bus_wstrb = '0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        k++;
        bus_raddr = a;
        @(negedge clk);
        k++;
        d = bus_rdata;
    endtask

    task automatic do_load();
        bus_write(6'd4, 32'h2, 4'hF);
        for (int i = 0; i < NCH; i++) begin
            a_per[i] = s_per[i]; a_dty[i] = s_dty[i]; a_ofs[i] = s_ofs[i];
        end
        k = 0;
    endtask

    task automatic wave_check(input string req, input int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            k++;
            for (int i = 0; i < NCH; i++) begin
                check(req, 32'(pwm_out[i]), 32'(model(k, a_per[i], a_dty[i], a_ofs[i])));
            end
        end
    endtask

    task automatic set_chan(input int ch, input logic [95:0] v);
        s_per[ch] = v[95:64]; s_dty[ch] = v[63:32]; s_ofs[ch] = v[31:0];
        bus_write(6'(16 + ch), s_per[ch], 4'hF);
        bus_write(6'(32 + ch), s_dty[ch], 4'hF);
        bus_write(6'(48 + ch), s_ofs[ch], 4'hF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        for (int i = 0; i < NCH; i++) begin
            a_per[i] = 0; a_dty[i] = 0; a_ofs[i] = 0;
            s_per[i] = 0; s_dty[i] = 0; s_ofs[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        check("R11 outputs after reset", 32'(pwm_out), 32'd0);
        bus_read(6'd16, rd); check("R11 period staged after reset", rd, 32'd0);
        bus_read(6'd50, rd); check("R11 offset staged after reset", rd, 32'd0);
        bus_read(6'd4, rd);  check("R11 control after reset", rd, 32'd0);

        // R1 / R2 fixed words
        bus_read(6'd3, rd); check("R1 id word", rd, 32'h601A3471);
        bus_read(6'd0, rd); check("R2 version word", rd, 32'h00020000);
        bus_read(6'd5, rd); check("R2 channel count", rd, 32'd3);

        // R5 R6 R7 R8: table walk, three channels rotated through the table
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < NCH; i++) set_chan(i, VEC[(v + i) % NV]);
            do_load();
            wave_check("R5 R6 R7 R8 waveform after load", 20);
        end

        // R3 readback and byte strobes
        bus_write(6'd33, 32'h11223344, 4'hF);
        bus_write(6'd33, 32'hAABBCCDD, 4'b0101);
        bus_read(6'd33, rd); check("R3 strobed duty ch1", rd, 32'h11BB33DD);
        bus_write(6'd33, s_dty[1], 4'hF);
        bus_read(6'd16, rd); check("R3 period ch0 readback", rd, s_per[0]);
        bus_read(6'd50, rd); check("R3 offset ch2 readback", rd, s_ofs[2]);

        // R4 staged writes do not reach outputs; load bit reads 0
        for (int i = 0; i < NCH; i++) set_chan(i, VEC[i]);
        do_load();
        wave_check("R4 before staging", 6);
        bus_write(6'd16, 32'd3, 4'hF);
        bus_write(6'd32, 32'd1, 4'hF);
        s_per[0] = 3; s_dty[0] = 1;
        wave_check("R4 staged not applied", 25);
        bus_read(6'd4, rd); check("R4 load bit self-clears", rd, 32'd0);
        do_load();
        wave_check("R4 staged applied on load", 12);

        // R9 halt
        bus_write(6'd4, 32'h1, 4'hF);
        for (int j = 0; j < 6; j++) begin
            @(negedge clk); k++;
            check("R9 outputs low while halted", 32'(pwm_out), 32'd0);
        end
        bus_read(6'd4, rd);  check("R9 halt bit reads back", rd, 32'd1);
        bus_read(6'd16, rd); check("R9 staged value kept", rd, 32'd3);
        bus_write(6'd4, 32'h0, 4'hF);
        k = 0;
        wave_check("R9 restart after halt clear", 20);

        // R10 unused words and out-of-range slots
        bus_read(6'd1, rd);  check("R10 unused word 0x04", rd, 32'd0);
        bus_read(6'd6, rd);  check("R10 unused word 0x18", rd, 32'd0);
        bus_read(6'd15, rd); check("R10 unused word 0x3C", rd, 32'd0);
        bus_write(6'd19, 32'hDEADBEEF, 4'hF);
        bus_write(6'd63, 32'h12345678, 4'hF);
        bus_read(6'd19, rd); check("R10 slot 3 period", rd, 32'd0);
        bus_read(6'd63, rd); check("R10 slot 15 offset", rd, 32'd0);
        bus_read(6'd35, rd); check("R10 slot 3 duty", rd, 32'd0);
        bus_read(6'd16, rd); check("R10 no alias into ch0", rd, s_per[0]);
        bus_write(6'd2, 32'hFFFFFFFF, 4'hF);
        bus_read(6'd4, rd);  check("R10 write to unused word", rd, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule